// File: doc/BRIEF.md
# Transactional Write-Back Cache with Overflow Store

This block is a small set-associative write-back data cache for a processor that can run transactions. Between a begin strobe and an end strobe, every line the processor loads or stores is marked as transactional. Transactional data is never written to memory until the transaction commits. An aborted transaction therefore leaves memory as it was before the transaction began.

When a transaction needs more lines in one set than the set has ways, a transactional line is moved into a small associative overflow store instead of being lost. The set is then flagged as overflowed. A later miss to a flagged set first looks in the overflow store, and a matching line is swapped back into the cache. On commit, the dirty overflow entries are written to memory and all marks are cleared. On abort, or when the overflow store has no room for a spill, the transactional lines and the overflow store are discarded. A conflict input from outside lets coherence logic abort the running transaction.

Top module: `txn_ovf_cache`

## Requirements
- R1: While reset is held and right after it, `ready` is 1, and `resp_valid`, `tx_active`, `tx_aborted`, `mem_rd` and `mem_wr` are 0.
- R2: Outside a transaction the cache is write-back. The set index is the low log2(SETS) address bits and the tag is the rest. On a miss, the victim is the lowest invalid way, or else the lowest valid way. A dirty victim is written to memory before its way is refilled, and a load returns the last value stored to the address.
- R3: A `tx_begin` strobe taken while `ready` is 1 sets `tx_active` and clears `tx_aborted`. A second begin inside a transaction has no effect, and `tx_end` outside a transaction has no effect.
- R4: Every load or store inside a transaction marks its line as transactional. A line that is dirty from before the transaction is first written to memory, so memory keeps its pre-transaction value.
- R5: On a transactional miss where every way of the set is marked, way 0 is moved into the overflow store and the set is flagged; memory is not written. A later access to a moved line gets its transactional value from the overflow store.
- R6: `tx_end` inside a transaction commits it: dirty overflow entries are written to memory, all marks and flags are cleared, and `tx_active` falls. Values stored in the transaction remain visible afterwards.
- R7: A `conflict_in` pulse during a transaction aborts it: `tx_active` falls, `tx_aborted` rises, and every value stored in the transaction is discarded. A pulse outside a transaction has no effect.
- R8: If a spill is needed and the overflow store is full, the transaction aborts as in R7. The access that caused the abort then completes as a non-transactional access.
- R9: `mem_rdata` is taken in the cycle after `mem_rd`, and `mem_rd` and `mem_wr` are never high together.
- R10: Each request accepted while `ready` is 1 makes `ready` fall and yields exactly one single-cycle `resp_valid` pulse. The pulse carries the loaded data, or for a store the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request, taken when `ready` is 1 |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| ready | output | 1 | Block idle, strobes and requests are taken |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load data or echoed store data |
| tx_begin | input | 1 | Begin-transaction strobe |
| tx_end | input | 1 | Commit strobe |
| conflict_in | input | 1 | External conflict, aborts a running transaction |
| tx_active | output | 1 | Transaction in progress |
| tx_aborted | output | 1 | Last transaction was aborted; cleared by begin |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_rd` |

## Verification
The bench builds the block with 4 sets, 2 ways and an overflow store of only 2 entries, on 8-bit addresses and data. With two ways, a third transactional line in one set forces a spill. It also allows repeated swaps between way 0 and the overflow store. With two overflow entries, the fifth transactional line of a set fills the store and forces the abort path. The same small geometry makes write-back of dirty victims outside a transaction occur after only three stores to one set.

// File: rtl/txc_pkg.sv
// Shared types for the transactional overflow cache.
// Assumes nothing beyond being compiled before the modules that import it.
package txc_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_FRD,
        ST_FWAIT,
        ST_ABORT,
        ST_COMMIT
    } txc_state_e;

    // Action chosen in one lookup cycle
    typedef enum logic [2:0] {
        ACT_HIT,
        ACT_HITWB,
        ACT_OINST,
        ACT_OSWAP,
        ACT_WB,
        ACT_FILL,
        ACT_SPILL,
        ACT_ABORT
    } txc_act_e;

endpackage

// File: rtl/txc_way_pick.sv
// Per-set way selection: tag match, lowest invalid way, lowest valid
// non-transactional way. Purely combinational.
// Assumes WAYS >= 2 and that at most one valid way matches a tag.
module txc_way_pick #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            v,
    input  logic [WAYS-1:0]            t,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       inv_any,
    output logic [WAY_W-1:0]           inv_way,
    output logic                       nt_any,
    output logic [WAY_W-1:0]           nt_way
);

    logic [WAYS-1:0] match;

    // one comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = v[g] && (tags[g] == lk_tag);
    end

    // priority encoders, lowest way wins
    always_comb begin
        hit = 1'b0;     hit_way = '0;
        inv_any = 1'b0; inv_way = '0;
        nt_any = 1'b0;  nt_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit = 1'b1; hit_way = WAY_W'(w);
            end
            if (!v[w]) begin
                inv_any = 1'b1; inv_way = WAY_W'(w);
            end
            if (v[w] && !t[w]) begin
                nt_any = 1'b1; nt_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/txc_ovf_table.sv
// Small fully associative store for spilled transactional lines.
// Assumes the controller never writes and kills in the same cycle and
// never stores one address twice.
module txc_ovf_table #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_dirty,
    output logic              free_any,
    output logic [IDX_W-1:0]  free_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    input  logic              kill_en,
    input  logic [IDX_W-1:0]  kill_idx,
    input  logic              clear_all,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0]             e_v;
    logic [DEPTH-1:0]             e_d;
    logic [DEPTH-1:0][ADDR_W-1:0] e_a;
    logic [DEPTH-1:0][DATA_W-1:0] e_q;
    logic [DEPTH-1:0]             match;

    // one address comparator per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = e_v[g] && (e_a[g] == lk_addr);
    end

    // lowest matching and lowest free entry
    always_comb begin
        lk_hit = 1'b0;   lk_idx = '0;
        free_any = 1'b0; free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1; lk_idx = IDX_W'(i);
            end
            if (!e_v[i]) begin
                free_any = 1'b1; free_idx = IDX_W'(i);
            end
        end
    end

    assign lk_data  = e_q[lk_idx];
    assign lk_dirty = e_d[lk_idx];
    assign rd_valid = e_v[rd_idx];
    assign rd_dirty = e_d[rd_idx];
    assign rd_addr  = e_a[rd_idx];
    assign rd_data  = e_q[rd_idx];

    // entry storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_v <= '0;
            e_d <= '0;
            e_a <= '0;
            e_q <= '0;
        end else if (clear_all) begin
            e_v <= '0;
            e_d <= '0;
        end else if (wr_en) begin
            e_v[wr_idx] <= 1'b1;
            e_d[wr_idx] <= wr_dirty;
            e_a[wr_idx] <= wr_addr;
            e_q[wr_idx] <= wr_data;
        end else if (kill_en) begin
            e_v[kill_idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/txn_ovf_cache.sv
// Set-associative write-back cache with per-line transactional marks,
// per-set overflow flags and a spill store for transactional lines.
// Assumes one-word lines, WAYS >= 2, OVF_DEPTH >= 2, and a memory that
// returns read data in the cycle after mem_rd.
module txn_ovf_cache
    import txc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int OVF_DEPTH = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int OVF_W = $clog2(OVF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    input  logic              tx_begin,
    input  logic              tx_end,
    input  logic              conflict_in,
    output logic              tx_active,
    output logic              tx_aborted,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    txc_state_e state;
    txc_act_e   act;
    logic [WAY_W-1:0] act_way;

    logic [SETS-1:0][WAYS-1:0]             ln_v, ln_d, ln_t;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  ln_tag;
    logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] ln_data;
    logic [SETS-1:0]                       o_bit;

    logic              r_we, resume, pend;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [WAY_W-1:0]  wb_way, fill_way;
    logic [OVF_W-1:0]  cidx;

    logic [SET_W-1:0] r_set;
    logic [TAG_W-1:0] r_tag;
    assign r_set = r_addr[SET_W-1:0];
    assign r_tag = r_addr[ADDR_W-1:SET_W];

    logic             hit, inv_any, nt_any;
    logic [WAY_W-1:0] hit_way, inv_way, nt_way;

    logic              o_hit, o_dirty, o_free_any, o_rd_v, o_rd_d;
    logic [OVF_W-1:0]  o_idx, o_free_idx;
    logic [DATA_W-1:0] o_data, o_rd_q;
    logic [ADDR_W-1:0] o_rd_a;
    logic              o_wr, o_kill, o_clear;
    logic [OVF_W-1:0]  o_wr_idx;
    logic              commit_last;

    txc_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pick (
        .v(ln_v[r_set]), .t(ln_t[r_set]), .tags(ln_tag[r_set]), .lk_tag(r_tag),
        .hit(hit), .hit_way(hit_way), .inv_any(inv_any), .inv_way(inv_way),
        .nt_any(nt_any), .nt_way(nt_way)
    );

    txc_ovf_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(OVF_DEPTH)) u_ovf (
        .clk(clk), .rst_n(rst_n), .lk_addr(r_addr),
        .lk_hit(o_hit), .lk_idx(o_idx), .lk_data(o_data), .lk_dirty(o_dirty),
        .free_any(o_free_any), .free_idx(o_free_idx),
        .wr_en(o_wr), .wr_idx(o_wr_idx), .wr_addr({ln_tag[r_set][0], r_set}),
        .wr_data(ln_data[r_set][0]), .wr_dirty(ln_d[r_set][0]),
        .kill_en(o_kill), .kill_idx(o_idx), .clear_all(o_clear),
        .rd_idx(cidx), .rd_valid(o_rd_v), .rd_dirty(o_rd_d),
        .rd_addr(o_rd_a), .rd_data(o_rd_q)
    );

    // choose the lookup action for the latched request
    always_comb begin
        act = ACT_HIT;
        act_way = hit_way;
        if (hit) begin
            if (tx_active && !ln_t[r_set][hit_way] && ln_d[r_set][hit_way])
                act = ACT_HITWB;
        end else if (o_bit[r_set] && o_hit) begin
            if (inv_any) begin
                act = ACT_OINST; act_way = inv_way;
            end else if (nt_any) begin
                act = ln_d[r_set][nt_way] ? ACT_WB : ACT_OINST;
                act_way = nt_way;
            end else begin
                act = ACT_OSWAP; act_way = '0;
            end
        end else if (inv_any) begin
            act = ACT_FILL; act_way = inv_way;
        end else if (nt_any) begin
            act = ln_d[r_set][nt_way] ? ACT_WB : ACT_FILL;
            act_way = nt_way;
        end else begin
            act = o_free_any ? ACT_SPILL : ACT_ABORT;
            act_way = '0;
        end
    end

    // overflow store controls
    assign commit_last = (state == ST_COMMIT) && (cidx == OVF_W'(OVF_DEPTH - 1));
    assign o_wr     = (state == ST_LOOK) && (act == ACT_SPILL || act == ACT_OSWAP);
    assign o_wr_idx = (act == ACT_OSWAP) ? o_idx : o_free_idx;
    assign o_kill   = (state == ST_LOOK) && (act == ACT_OINST);
    assign o_clear  = (state == ST_ABORT) || commit_last;

    // memory port, driven from registered state only
    always_comb begin
        mem_rd    = (state == ST_FRD);
        mem_wr    = (state == ST_WB) || ((state == ST_COMMIT) && o_rd_v && o_rd_d);
        mem_addr  = r_addr;
        mem_wdata = ln_data[r_set][wb_way];
        if (state == ST_WB)
            mem_addr = {ln_tag[r_set][wb_way], r_set};
        else if (state == ST_COMMIT) begin
            mem_addr  = o_rd_a;
            mem_wdata = o_rd_q;
        end
    end

    assign ready = (state == ST_IDLE) && !pend;

    // pending external conflict
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (state == ST_ABORT || commit_last)
            pend <= 1'b0;
        else if (conflict_in && tx_active && state != ST_COMMIT)
            pend <= 1'b1;
    end

    // controller, line arrays and transaction status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ln_v <= '0; ln_d <= '0; ln_t <= '0;
            ln_tag <= '0; ln_data <= '0; o_bit <= '0;
            r_we <= 1'b0; r_addr <= '0; r_wdata <= '0;
            wb_way <= '0; fill_way <= '0; cidx <= '0; resume <= 1'b0;
            tx_active <= 1'b0; tx_aborted <= 1'b0;
            resp_valid <= 1'b0; resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (pend) begin
                        resume <= 1'b0;
                        state  <= ST_ABORT;
                    end else if (tx_end && tx_active) begin
                        cidx  <= '0;
                        state <= ST_COMMIT;
                    end else if (tx_begin) begin
                        if (!tx_active) begin
                            tx_active  <= 1'b1;
                            tx_aborted <= 1'b0;
                        end
                    end else if (req_valid) begin
                        r_we <= req_we; r_addr <= req_addr; r_wdata <= req_wdata;
                        state <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    case (act)
                        ACT_HIT: begin
                            if (r_we) begin
                                ln_data[r_set][act_way] <= r_wdata;
                                ln_d[r_set][act_way]    <= 1'b1;
                            end
                            if (tx_active) ln_t[r_set][act_way] <= 1'b1;
                            resp_valid <= 1'b1;
                            resp_rdata <= r_we ? r_wdata : ln_data[r_set][act_way];
                            state <= ST_IDLE;
                        end
                        ACT_HITWB, ACT_WB: begin
                            wb_way <= act_way;
                            state  <= ST_WB;
                        end
                        ACT_OINST, ACT_OSWAP: begin
                            ln_v[r_set][act_way]    <= 1'b1;
                            ln_t[r_set][act_way]    <= 1'b1;
                            ln_d[r_set][act_way]    <= o_dirty;
                            ln_tag[r_set][act_way]  <= r_tag;
                            ln_data[r_set][act_way] <= o_data;
                        end
                        ACT_SPILL: begin
                            ln_v[r_set][0] <= 1'b0;
                            ln_t[r_set][0] <= 1'b0;
                            ln_d[r_set][0] <= 1'b0;
                            o_bit[r_set]   <= 1'b1;
                        end
                        ACT_FILL: begin
                            fill_way <= act_way;
                            state    <= ST_FRD;
                        end
                        default: begin
                            resume <= 1'b1;
                            state  <= ST_ABORT;
                        end
                    endcase
                end
                ST_WB: begin
                    ln_d[r_set][wb_way] <= 1'b0;
                    state <= ST_LOOK;
                end
                ST_FRD: state <= ST_FWAIT;
                ST_FWAIT: begin
                    ln_v[r_set][fill_way]    <= 1'b1;
                    ln_t[r_set][fill_way]    <= 1'b0;
                    ln_d[r_set][fill_way]    <= 1'b0;
                    ln_tag[r_set][fill_way]  <= r_tag;
                    ln_data[r_set][fill_way] <= mem_rdata;
                    state <= ST_LOOK;
                end
                ST_ABORT: begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            if (ln_t[s][w]) begin
                                ln_v[s][w] <= 1'b0;
                                ln_t[s][w] <= 1'b0;
                                ln_d[s][w] <= 1'b0;
                            end
                    o_bit      <= '0;
                    tx_active  <= 1'b0;
                    tx_aborted <= 1'b1;
                    state      <= resume ? ST_LOOK : ST_IDLE;
                end
                ST_COMMIT: begin
                    if (commit_last) begin
                        ln_t      <= '0;
                        o_bit     <= '0;
                        tx_active <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        cidx <= cidx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txc_checker.sv
// Temporal checks on the transactional overflow cache, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module txc_checker #(
    parameter int SETS = 4,
    parameter int WAYS = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ready,
    input logic                      req_valid,
    input logic                      tx_begin,
    input logic                      tx_end,
    input logic                      tx_active,
    input logic                      tx_aborted,
    input logic                      resp_valid,
    input logic                      mem_rd,
    input logic                      mem_wr,
    input logic [SETS-1:0]           o_bit,
    input logic [SETS-1:0][WAYS-1:0] t_bits
);

    assert_mem_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_marks_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (o_bit == '0 && t_bits == '0));

    assert_begin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready && tx_begin |=> tx_active && !tx_aborted);

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_aborted) |-> !tx_active);

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready && req_valid && !tx_begin && !(tx_end && tx_active) |=> !ready);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_flag_in_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|o_bit) |-> tx_active);

endmodule

bind txn_ovf_cache txc_checker #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .req_valid(req_valid),
    .tx_begin(tx_begin), .tx_end(tx_end), .tx_active(tx_active),
    .tx_aborted(tx_aborted), .resp_valid(resp_valid), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .o_bit(o_bit), .t_bits(ln_t)
);

// File: tb/tb_txn_ovf_cache.sv
// Self-checking bench: a behavioural transaction model (committed image,
// shadow writes, per-set footprint) predicts every response and status.
module tb_txn_ovf_cache;

    localparam int AW = 8, DW = 8, SETS = 4, WAYS = 2, DEPTH = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_we = 0, tx_begin = 0, tx_end = 0, conflict_in = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready, resp_valid, tx_active, tx_aborted, mem_rd, mem_wr;
    logic [DW-1:0] resp_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    txn_ovf_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(SETS), .WAYS(WAYS),
                    .OVF_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .tx_begin(tx_begin),
        .tx_end(tx_end), .conflict_in(conflict_in), .tx_active(tx_active),
        .tx_aborted(tx_aborted), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // backing memory, read data one cycle after mem_rd
    logic [DW-1:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // reference model state
    logic [DW-1:0] arch [256];
    logic [DW-1:0] sh [int];
    bit touched [int];
    bit m_active = 0, m_aborted = 0;
    initial for (int i = 0; i < 256; i++) arch[i] = 8'(i) ^ 8'h5A;

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int set_count(int s);
        int n = 0;
        foreach (touched[k]) if ((k % SETS) == s) n++;
        return n;
    endfunction

    function automatic int occupancy();
        int tot = 0;
        for (int s = 0; s < SETS; s++) begin
            int n = set_count(s);
            if (n > WAYS) tot += n - WAYS;
        end
        return tot;
    endfunction

    function automatic void m_abort();
        sh.delete(); touched.delete();
        m_active = 0; m_aborted = 1;
    endfunction

    // R9: checked on every clock
    always @(negedge clk) if (rst_n && !done)
        chk(!(mem_rd && mem_wr), "R9 rd/wr overlap", {mem_rd, mem_wr}, 0);

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic status(string rq);
        chk(tx_active == m_active, {rq, " tx_active"}, tx_active, m_active);
        chk(tx_aborted == m_aborted, {rq, " tx_aborted"}, tx_aborted, m_aborted);
    endtask

    task automatic access(bit we, int a, int d, string rq);
        logic [DW-1:0] exp;
        if (m_active && !touched.exists(a)) begin
            if (set_count(a % SETS) >= WAYS && occupancy() >= DEPTH) m_abort();
            else touched[a] = 1;
        end
        if (we) begin
            if (m_active) sh[a] = 8'(d); else arch[a] = 8'(d);
            exp = 8'(d);
        end else
            exp = (m_active && sh.exists(a)) ? sh[a] : arch[a];
        wait_ready();
        req_valid = 1; req_we = we; req_addr = 8'(a); req_wdata = 8'(d);
        @(negedge clk);
        req_valid = 0;
        chk(!ready, "R10 busy after accept", ready, 0);
        while (!resp_valid) @(negedge clk);
        chk(resp_rdata == exp, {rq, " data"}, resp_rdata, exp);
        @(negedge clk);
        chk(!resp_valid, "R10 single pulse", resp_valid, 0);
        wait_ready();
        status(rq);
    endtask

    task automatic begin_tx(string rq);
        if (!m_active) begin m_active = 1; m_aborted = 0; end
        wait_ready();
        tx_begin = 1; @(negedge clk); tx_begin = 0;
        wait_ready(); status(rq);
    endtask

    task automatic end_tx(string rq);
        if (m_active) begin
            foreach (sh[k]) arch[k] = sh[k];
            sh.delete(); touched.delete(); m_active = 0;
        end
        wait_ready();
        tx_end = 1; @(negedge clk); tx_end = 0;
        @(negedge clk); wait_ready(); status(rq);
    endtask

    task automatic conflict(string rq);
        if (m_active) m_abort();
        wait_ready();
        conflict_in = 1; @(negedge clk); conflict_in = 0;
        @(negedge clk); wait_ready(); status(rq);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready, "R1 ready", ready, 1);
        chk(!resp_valid && !tx_active && !tx_aborted, "R1 outputs",
            {resp_valid, tx_active, tx_aborted}, 0);
        chk(!mem_rd && !mem_wr, "R1 mem idle", {mem_rd, mem_wr}, 0);
        rst_n = 1;
        @(negedge clk);
        status("R1 after reset");

        // R2: write-back caching outside a transaction
        access(1, 'h10, 'hA1, "R2 store");
        access(0, 'h10, 0, "R2 load");
        access(1, 'h14, 'hB2, "R2 store");
        access(1, 'h18, 'hC3, "R2 evict");
        chk(mem['h10] == 8'hA1, "R2 dirty victim written", mem['h10], 'hA1);
        access(0, 'h10, 0, "R2 reload");
        chk(mem['h18] == 8'hC3, "R2 second victim", mem['h18], 'hC3);

        // R7 / R3: strobes that must be ignored
        conflict("R7 conflict outside tx");
        end_tx("R3 end outside tx");

        // R3 / R5 / R6: spill, swap back, commit
        begin_tx("R3 begin");
        begin_tx("R3 nested begin");
        access(1, 'h21, 'h11, "R4 tx store");
        access(1, 'h25, 'h22, "R4 tx store");
        access(1, 'h29, 'h33, "R5 store forcing spill");
        chk(mem['h21] == 8'h7B, "R5 spill leaves memory", mem['h21], 'h7B);
        access(0, 'h21, 0, "R5 load spilled line");
        access(0, 'h29, 0, "R5 load swapped line");
        access(0, 'h25, 0, "R5 load resident line");
        end_tx("R6 commit");
        chk(mem['h21] == 8'h11, "R6 overflow written on commit", mem['h21], 'h11);
        access(0, 'h21, 0, "R6 after commit");
        access(0, 'h25, 0, "R6 after commit");
        access(0, 'h29, 0, "R6 after commit");

        // R4 / R7: pre-transaction dirty line and external abort
        access(1, 'h32, 'h44, "R2 store");
        begin_tx("R3 begin");
        access(1, 'h32, 'h55, "R4 tx store on dirty line");
        chk(mem['h32] == 8'h44, "R4 pre-tx value saved", mem['h32], 'h44);
        access(0, 'h32, 0, "R4 tx load");
        conflict("R7 abort");
        access(0, 'h32, 0, "R7 value rolled back");
        access(0, 'h29, 0, "R7 committed data kept");

        // R8: overflow store full
        begin_tx("R3 begin clears aborted");
        access(1, 'h03, 'h61, "R8 fill");
        access(1, 'h07, 'h62, "R8 fill");
        access(1, 'h0B, 'h63, "R8 spill one");
        access(1, 'h0F, 'h64, "R8 spill two");
        access(1, 'h13, 'h65, "R8 store on full store");
        chk(tx_aborted, "R8 aborted", tx_aborted, 1);
        access(0, 'h03, 0, "R8 discarded");
        access(0, 'h0B, 0, "R8 discarded");
        access(0, 'h13, 0, "R8 non-tx store kept");
        chk(mem['h03] == 8'h59, "R8 memory untouched", mem['h03], 'h59);

        done = 1;
        summary();
        $finish;
    end

endmodule